// File: doc/BRIEF.md
# Input-First Virtual Channel Allocator

This block assigns output virtual channels to packets waiting at the inputs of a five-port router. Each input VC that holds a routed head flit raises a request. The request names the output port it must leave by and a mask of the output VCs it may legally use on that port. The routing stage has already narrowed that mask to the VCs its message class is allowed to use, so the allocator has no class logic of its own.

Allocation is separable and runs in two stages within one combinational pass:
- **Input side.** Each input VC runs a round-robin choice among its free candidate output VCs and picks one.
- **Output side.** Each output VC runs a round-robin choice among the input VCs that picked it.

A winner gets its output VC in the same cycle. That output VC stays busy until the output unit reports that the tail flit of the packet has left.

Ports may carry different numbers of VCs. VC slots that do not exist are tied to constants, so they never request, never win and never show busy.

The request side follows a valid/ready discipline:
- An input VC asserts its request bit and holds port and mask steady until its grant bit rises in the same cycle. The grant acts as the ready.
- A request that is not granted costs nothing. It may be held, changed or withdrawn on the next cycle.
- There is no other back-pressure. Credit state and tail releases arrive on plain level pins.

Top module: `vc_allocator`

## Requirements
- R1: After reset every output VC is free (`ovc_busy` all zero) and no grant is raised while no request is present.
- R2: A grant names an output VC that exists, lies on the requested port, is set in the request mask, is free and has credit. The grant appears combinationally in the cycle of the request. `grant_vc` of input VC i is the binary VC index within the requested port, in bits [i*VC_W +: VC_W]. Flat VC index i means port i/MAX_VCS, VC i%MAX_VCS.
- R3: In any cycle each output VC is granted to at most one input VC, and each input VC receives at most one output VC. Requests with disjoint masks to the same port are all granted together.
- R4: An output VC granted at a clock edge is busy from that edge on. It cannot be granted again until `ovc_release` is high for it at an edge, after which it is free. A release on a free output VC has no effect.
- R5: An output VC whose `ovc_credit_ok` bit is low is never granted. The input VC's choice falls to another free candidate instead.
- R6: The input-side choice is round-robin. It starts at the VC after the last one granted to that input VC (VC 0 after reset), and its pointer moves only when that input VC is granted.
- R7: The output-side choice is round-robin over flat input VC index. It starts after the last input VC granted that output VC (index 0 after reset).
- R8: Allocation is input-first. An input VC whose single pick loses at the output side gets no grant that cycle, even if another of its candidates is free.
- R9: Per-port VC counts come from `VC_COUNTS`; the default is 4, 2, 3, 4, 1 for ports 0..4. Mask bits for nonexistent output VCs are never granted, nonexistent input VCs never receive a grant, and busy bits of nonexistent output VCs stay 0.
- R10: A request whose port field is not below NUM_PORTS is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NIV | Request bit per input VC |
| req_port | input | NIV*PORT_W | Target output port per input VC |
| req_vc_mask | input | NIV*MAX_VCS | Legal output VCs per input VC |
| ovc_credit_ok | input | NOV | Output VC has at least one downstream credit |
| ovc_release | input | NOV | Tail flit of the holding packet has left |
| grant_valid | output | NIV | Input VC granted this cycle (acts as ready) |
| grant_vc | output | NIV*VC_W | Granted VC index within the requested port |
| ovc_busy | output | NOV | Output VC currently allocated |

## Verification
A corrupted busy bit shows at the ports on the very next request for that output VC. A stuck busy bit withholds a grant. A lost busy bit grants the same VC twice, and the bench sees that in the cycle of the second request.

A round-robin pointer that moves when it should not only shows later, when the same requesters return. The bench therefore replays each contention pattern after a release and checks which requester or VC wins the second round.

The input-first loss case is set up so that a wrongly advanced input pointer changes the next grant's VC index.

// File: rtl/vca_pkg.sv
package vca_pkg;
  // width of one per-port VC count field inside VC_COUNTS
  localparam int unsigned CNT_W = 4;
endpackage

// File: rtl/vca_rr_arb.sv
module vca_rr_arb #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         advance,
  output logic [N-1:0] gnt
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q;
  logic [IW-1:0] nxt_ptr;
  logic          found;

  // search starts at the pointer and wraps
  always_comb begin
    gnt   = '0;
    found = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      int unsigned idx;
      idx = (int'(ptr_q) + i) % N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    nxt_ptr = ptr_q;
    for (int i = 0; i < int'(N); i++) begin
      if (gnt[i]) nxt_ptr = IW'((i + 1) % N);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               ptr_q <= '0;
    else if (advance && found) ptr_q <= nxt_ptr;
  end

  AST_ARB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R3
  AST_ARB_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0); // R2
endmodule

// File: rtl/vca_input_stage.sv
module vca_input_stage #(
  parameter int unsigned NUM_PORTS = 5,
  parameter int unsigned MAX_VCS   = 4,
  parameter int unsigned PORT_W    = 3,
  parameter int unsigned VC_W      = 2,
  parameter bit          ACTIVE    = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic [PORT_W-1:0]              req_port,
  input  logic [MAX_VCS-1:0]             req_mask,
  input  logic [NUM_PORTS*MAX_VCS-1:0]   avail,
  input  logic                           granted,
  output logic                           pick_valid,
  output logic [MAX_VCS-1:0]             pick,
  output logic [VC_W-1:0]                pick_vc
);
  generate
    if (ACTIVE) begin : g_live
      logic [MAX_VCS-1:0] cand;

      // candidates: legal, existing, free and credited VCs of the target port
      always_comb begin
        cand = '0;
        if (req_valid && (int'(req_port) < int'(NUM_PORTS)))
          cand = req_mask & avail[int'(req_port)*MAX_VCS +: MAX_VCS];
      end

      vca_rr_arb #(.N(MAX_VCS)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (cand),
        .advance (granted),
        .gnt     (pick)
      );

      always_comb begin
        pick_vc = '0;
        for (int v = 0; v < int'(MAX_VCS); v++) begin
          if (pick[v]) pick_vc = VC_W'(v);
        end
      end
      assign pick_valid = |pick;

      AST_GRANT_NEEDS_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        granted |-> pick_valid); // R8
      AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick)); // R3
    end else begin : g_tied
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst_n, req_valid, req_port, req_mask, avail, granted};
      assign pick_valid = 1'b0;
      assign pick       = '0;
      assign pick_vc    = '0;
    end
  endgenerate
endmodule

// File: rtl/vca_output_stage.sv
module vca_output_stage #(
  parameter int unsigned NIV    = 20,
  parameter bit          ACTIVE = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NIV-1:0] req,
  input  logic           release_i,
  output logic [NIV-1:0] gnt,
  output logic           busy
);
  generate
    if (ACTIVE) begin : g_live
      logic busy_q;

      vca_rr_arb #(.N(NIV)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .advance (1'b1),
        .gnt     (gnt)
      );

      // allocation holds until the tail leaves
      always_ff @(posedge clk) begin
        if (!rst_n)         busy_q <= 1'b0;
        else if (|gnt)      busy_q <= 1'b1;
        else if (release_i) busy_q <= 1'b0;
      end
      assign busy = busy_q;

      AST_OVC_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R3
      AST_OVC_GRANT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |-> !busy_q); // R4
      AST_OVC_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |=> busy_q); // R4
      AST_OVC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !release_i) |=> busy_q); // R4
      AST_OVC_FREED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && release_i) |=> !busy_q); // R4
    end else begin : g_tied
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst_n, req, release_i};
      assign gnt  = '0;
      assign busy = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/vc_allocator.sv
module vc_allocator #(
  parameter int unsigned NUM_PORTS = 5,
  parameter int unsigned MAX_VCS   = 4,
  // one 4-bit count per port, port 0 in the low nibble
  parameter logic [NUM_PORTS*vca_pkg::CNT_W-1:0] VC_COUNTS = {4'd1, 4'd4, 4'd3, 4'd2, 4'd4},
  localparam int unsigned PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int unsigned VC_W   = (MAX_VCS > 1) ? $clog2(MAX_VCS) : 1,
  localparam int unsigned NIV    = NUM_PORTS * MAX_VCS,
  localparam int unsigned NOV    = NUM_PORTS * MAX_VCS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NIV-1:0]          req_valid,
  input  logic [NIV*PORT_W-1:0]   req_port,
  input  logic [NIV*MAX_VCS-1:0]  req_vc_mask,
  input  logic [NOV-1:0]          ovc_credit_ok,
  input  logic [NOV-1:0]          ovc_release,
  output logic [NIV-1:0]          grant_valid,
  output logic [NIV*VC_W-1:0]     grant_vc,
  output logic [NOV-1:0]          ovc_busy
);
  import vca_pkg::*;

  logic [NOV-1:0]     exists;
  logic [NOV-1:0]     avail;
  logic [NIV-1:0]     pick_valid;
  logic [MAX_VCS-1:0] pick     [NIV];
  logic [VC_W-1:0]    pick_vc  [NIV];
  logic [NIV-1:0]     ovc_req  [NOV];
  logic [NIV-1:0]     ovc_gnt  [NOV];

  // static existence map from the per-port counts
  generate
    for (genvar p = 0; p < int'(NUM_PORTS); p++) begin : g_exist_p
      localparam int unsigned CNT = int'(VC_COUNTS[p*CNT_W +: CNT_W]);
      for (genvar v = 0; v < int'(MAX_VCS); v++) begin : g_exist_v
        assign exists[p*MAX_VCS+v] = (v < int'(CNT));
      end
    end
  endgenerate

  assign avail = exists & ~ovc_busy & ovc_credit_ok;

  // first stage: one arbiter per input VC
  generate
    for (genvar i = 0; i < int'(NIV); i++) begin : g_in
      localparam int unsigned IP  = i / MAX_VCS;
      localparam int unsigned IV  = i % MAX_VCS;
      localparam int unsigned CNT = int'(VC_COUNTS[IP*CNT_W +: CNT_W]);

      vca_input_stage #(
        .NUM_PORTS (NUM_PORTS),
        .MAX_VCS   (MAX_VCS),
        .PORT_W    (PORT_W),
        .VC_W      (VC_W),
        .ACTIVE    (IV < CNT)
      ) u_in (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid[i]),
        .req_port   (req_port[i*PORT_W +: PORT_W]),
        .req_mask   (req_vc_mask[i*MAX_VCS +: MAX_VCS]),
        .avail      (avail),
        .granted    (grant_valid[i]),
        .pick_valid (pick_valid[i]),
        .pick       (pick[i]),
        .pick_vc    (pick_vc[i])
      );

      assign grant_vc[i*VC_W +: VC_W] = grant_valid[i] ? pick_vc[i] : '0;
    end
  endgenerate

  // route each pick to the output VC it names
  generate
    for (genvar o = 0; o < int'(NOV); o++) begin : g_route
      localparam int unsigned OP = o / MAX_VCS;
      localparam int unsigned OV = o % MAX_VCS;
      for (genvar i = 0; i < int'(NIV); i++) begin : g_src
        assign ovc_req[o][i] = pick_valid[i] && pick[i][OV] &&
                               (req_port[i*PORT_W +: PORT_W] == PORT_W'(OP));
      end
    end
  endgenerate

  // second stage: one arbiter and status bit per output VC
  generate
    for (genvar o = 0; o < int'(NOV); o++) begin : g_out
      localparam int unsigned OP  = o / MAX_VCS;
      localparam int unsigned OV  = o % MAX_VCS;
      localparam int unsigned CNT = int'(VC_COUNTS[OP*CNT_W +: CNT_W]);

      vca_output_stage #(
        .NIV    (NIV),
        .ACTIVE (OV < CNT)
      ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (ovc_req[o]),
        .release_i (ovc_release[o]),
        .gnt       (ovc_gnt[o]),
        .busy      (ovc_busy[o])
      );
    end
  endgenerate

  always_comb begin
    grant_valid = '0;
    for (int o = 0; o < int'(NOV); o++) grant_valid = grant_valid | ovc_gnt[o];
  end

  generate
    for (genvar i = 0; i < int'(NIV); i++) begin : g_chk
      AST_GRANT_HAS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid[i] |->
          ovc_credit_ok[int'(req_port[i*PORT_W +: PORT_W])*MAX_VCS + int'(grant_vc[i*VC_W +: VC_W])]); // R5
      AST_GRANT_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid[i] |-> req_vc_mask[i*MAX_VCS + int'(grant_vc[i*VC_W +: VC_W])]); // R2
    end
  endgenerate

  AST_TIED_NEVER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovc_busy & ~exists) == '0); // R9
endmodule

// File: tb/vc_allocator_tb.sv
module vc_allocator_tb;
  localparam int NP = 5;
  localparam int MV = 4;
  localparam int PW = 3;
  localparam int VW = 2;
  localparam int NI = NP * MV;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NI-1:0]   req_valid;
  logic [NI*PW-1:0] req_port;
  logic [NI*MV-1:0] req_vc_mask;
  logic [NI-1:0]   ovc_credit_ok;
  logic [NI-1:0]   ovc_release;
  logic [NI-1:0]   grant_valid;
  logic [NI*VW-1:0] grant_vc;
  logic [NI-1:0]   ovc_busy;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  vc_allocator u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_port      (req_port),
    .req_vc_mask   (req_vc_mask),
    .ovc_credit_ok (ovc_credit_ok),
    .ovc_release   (ovc_release),
    .grant_valid   (grant_valid),
    .grant_vc      (grant_vc),
    .ovc_busy      (ovc_busy)
  );

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic clear_inputs();
    req_valid   = '0;
    req_port    = '0;
    req_vc_mask = '0;
    ovc_release = '0;
    ovc_credit_ok = '1;
  endtask

  task automatic reset_dut();
    clear_inputs();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
  endtask

  task automatic set_req(input int iv, input int port, input logic [3:0] mask);
    req_valid[iv]          = 1'b1;
    req_port[iv*PW +: PW]  = PW'(port);
    req_vc_mask[iv*MV +: MV] = mask;
  endtask

  task automatic drop_req(input int iv);
    req_valid[iv] = 1'b0;
  endtask

  task automatic expect_grant(input string tag, input int iv, input bit ev, input int evc);
    n_checks++;
    if (grant_valid[iv] !== ev || (ev && int'(grant_vc[iv*VW +: VW]) != evc)) begin
      n_fail++;
      $display("FAIL %s: input VC %0d grant=%0b vc=%0d, expected grant=%0b vc=%0d",
               tag, iv, grant_valid[iv], grant_vc[iv*VW +: VW], ev, evc);
    end
  endtask

  task automatic expect_busy(input string tag, input int ovc, input bit eb);
    n_checks++;
    if (ovc_busy[ovc] !== eb) begin
      n_fail++;
      $display("FAIL %s: output VC %0d busy=%0b, expected %0b", tag, ovc, ovc_busy[ovc], eb);
    end
  endtask

  task automatic expect_vec(input string tag, input logic [NI-1:0] act, input logic [NI-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h, expected %h", tag, act, exp);
    end
  endtask

  task automatic t_reset_state();
    reset_dut();
    settle();
    expect_vec("R1 busy after reset", ovc_busy, '0);
    expect_vec("R1 no grant idle", grant_valid, '0);
  endtask

  task automatic t_basic_busy_release();
    reset_dut();
    set_req(0, 3, 4'b0001);
    settle();
    expect_grant("R2 basic grant", 0, 1'b1, 0);
    tick();
    expect_busy("R4 busy after grant", 12, 1'b1);
    drop_req(0);
    set_req(1, 3, 4'b0001);
    settle();
    expect_grant("R4 busy VC withheld", 1, 1'b0, 0);
    ovc_release[12] = 1'b1;
    tick();
    ovc_release[12] = 1'b0;
    settle();
    expect_busy("R4 freed by release", 12, 1'b0);
    expect_grant("R4 grant after release", 1, 1'b1, 0);
    drop_req(1);
    tick();
    ovc_release[8] = 1'b1;
    tick();
    ovc_release[8] = 1'b0;
    expect_busy("R4 release on free VC ignored", 8, 1'b0);
    set_req(2, 2, 4'b0001);
    settle();
    expect_grant("R4 VC usable after idle release", 2, 1'b1, 0);
  endtask

  task automatic t_credit();
    reset_dut();
    ovc_credit_ok[8] = 1'b0;
    set_req(4, 2, 4'b0001);
    settle();
    expect_grant("R5 no credit no grant", 4, 1'b0, 0);
    set_req(4, 2, 4'b0011);
    settle();
    expect_grant("R5 falls to credited VC", 4, 1'b1, 1);
    tick();
    expect_busy("R5 credited VC taken", 9, 1'b1);
    expect_busy("R5 uncredited VC untouched", 8, 1'b0);
  endtask

  task automatic t_parallel();
    reset_dut();
    set_req(0, 3, 4'b0001);
    set_req(1, 3, 4'b0010);
    set_req(2, 3, 4'b0100);
    set_req(3, 3, 4'b1000);
    settle();
    for (int k = 0; k < 4; k++) expect_grant("R3 disjoint masks all granted", k, 1'b1, k);
    tick();
    req_valid = '0;
    expect_vec("R3 four VCs busy", ovc_busy, 20'h0F000);
    reset_dut();
    for (int k = 0; k < 4; k++) set_req(k, 3, 4'b1111);
    settle();
    n_checks++;
    if ($countones(grant_valid) != 1) begin
      n_fail++;
      $display("FAIL R3 shared pick: %0d grants, expected 1", $countones(grant_valid));
    end
    expect_grant("R3 lowest wins at reset pointer", 0, 1'b1, 0);
  endtask

  task automatic t_input_rr();
    reset_dut();
    set_req(0, 0, 4'b1111);
    settle();
    expect_grant("R6 first pick VC0", 0, 1'b1, 0);
    tick();
    drop_req(0);
    ovc_release[0] = 1'b1;
    tick();
    ovc_release[0] = 1'b0;
    set_req(0, 0, 4'b1111);
    settle();
    expect_grant("R6 rotates to VC1", 0, 1'b1, 1);
  endtask

  task automatic t_output_rr();
    reset_dut();
    set_req(0, 3, 4'b0001);
    set_req(4, 3, 4'b0001);
    settle();
    expect_grant("R7 index 0 wins first", 0, 1'b1, 0);
    expect_grant("R7 index 4 loses first", 4, 1'b0, 0);
    tick();
    req_valid = '0;
    ovc_release[12] = 1'b1;
    tick();
    ovc_release[12] = 1'b0;
    set_req(0, 3, 4'b0001);
    set_req(4, 3, 4'b0001);
    settle();
    expect_grant("R7 index 4 wins second", 4, 1'b1, 0);
    expect_grant("R7 index 0 loses second", 0, 1'b0, 0);
  endtask

  task automatic t_input_first_loss();
    reset_dut();
    set_req(0, 3, 4'b0011);
    set_req(4, 3, 4'b0011);
    settle();
    expect_grant("R8 winner", 0, 1'b1, 0);
    expect_grant("R8 loser gets nothing", 4, 1'b0, 0);
    tick();
    req_valid = '0;
    ovc_release[12] = 1'b1;
    tick();
    ovc_release[12] = 1'b0;
    tick();
    set_req(4, 3, 4'b0011);
    settle();
    expect_grant("R6 pointer held on loss", 4, 1'b1, 0);
  endtask

  task automatic t_tied_vcs();
    reset_dut();
    set_req(16, 4, 4'b1110);
    set_req(7, 0, 4'b1111);
    set_req(5, 1, 4'b1100);
    settle();
    expect_grant("R9 missing VCs on port 4", 16, 1'b0, 0);
    expect_grant("R9 missing input VC", 7, 1'b0, 0);
    expect_grant("R9 missing VCs on port 1", 5, 1'b0, 0);
    tick();
    expect_vec("R9 nothing busy", ovc_busy, '0);
    set_req(16, 4, 4'b1111);
    settle();
    expect_grant("R9 single VC port usable", 16, 1'b1, 0);
  endtask

  task automatic t_bad_port();
    reset_dut();
    set_req(0, 5, 4'b1111);
    set_req(1, 7, 4'b1111);
    settle();
    expect_grant("R10 port 5", 0, 1'b0, 0);
    expect_grant("R10 port 7", 1, 1'b0, 0);
    tick();
    expect_vec("R10 nothing busy", ovc_busy, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    clear_inputs();
    t_reset_state();
    t_basic_busy_release();
    t_credit();
    t_parallel();
    t_input_rr();
    t_output_rr();
    t_input_first_loss();
    t_tied_vcs();
    t_bad_port();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule